// File: doc/BRIEF.md
# Weighted Adaptive Egress Port Selector

This block decides, for every packet a switch forwards, which egress port it leaves on. The packet arrives with the number of its multipath group. A membership table maps that group to a set of candidate ports. Among the candidates that are not marked down, the block picks the one that currently looks least loaded, and returns the pick two cycles later. It accepts a new packet every cycle.

Per-port queue depths reach the block as live counters, but decisions never use them directly. The block copies all of them in a single cycle into a snapshot at a programmable interval, and each decision reads only that snapshot. In the normal mode the shallowest snapshot queue wins. When the fabric is flagged as asymmetric, each candidate is scored as a normalization factor times its snapshot depth minus a per-port bandwidth weight, and the lowest score wins. The control path outside the block writes the weights slowly, and every packet reads them as they stand. When no candidate remains, the block reports a no-route drop.

Top module: `egress_port_selector`

## Requirements
- R1: Only ports whose bit is set in the packet's group entry are candidates, with bit i meaning port i. An entry is written through the table write port. A packet that looks up the same group in the cycle of a write sees the previous entry.
- R2: With `asym_mode_i` = 0, the candidate with the smallest snapshot occupancy is chosen.
- R3: With `asym_mode_i` = 1, each candidate's signed score is `norm_i * occupancy - weight`, and the lowest score is chosen. Port i's occupancy is `occ_live_i[i*OCC_W +: OCC_W]` and its weight is `weight_i[i*WT_W +: WT_W]`.
- R4: When scores (or occupancies) are equal, the lowest port index wins.
- R5: A port whose bit is set in `port_down_i` is never chosen.
- R6: If no candidate remains, the result carries `sel_drop_o` = 1 and `sel_port_o` = 0, and `sel_valid_o` is still raised.
- R7: The snapshot of all ports is replaced in one cycle, once every `sample_period_i`+1 cycles counted from reset. A decision uses the snapshot held at the clock edge where its packet is accepted, and never the live counters.
- R8: A packet accepted at one edge has its result on the outputs after the second edge following it. Back-to-back packets are each answered, and `sel_valid_o` is high only for accepted packets.
- R9: The weights, the normalization factor, the mode and the down mask are taken as they are at the packet's acceptance edge.
- R10: Reset clears the outputs and the snapshot to zero, so a packet accepted before the first refresh sees every occupancy as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid_i | input | 1 | Packet decision request |
| pkt_group_i | input | GID_W | Group number of the packet |
| tbl_we_i | input | 1 | Membership table write enable |
| tbl_addr_i | input | GID_W | Group written |
| tbl_mask_i | input | NPORT | Port membership bits written |
| occ_live_i | input | NPORT*OCC_W | Live queue occupancy per port |
| weight_i | input | NPORT*WT_W | Bandwidth weight per port |
| port_down_i | input | NPORT | Ports excluded from selection |
| asym_mode_i | input | 1 | 1 selects weighted scoring |
| norm_i | input | NORM_W | Queue-to-weight normalization factor |
| sample_period_i | input | PER_W | Snapshot interval minus one |
| sel_valid_o | output | 1 | Result strobe |
| sel_drop_o | output | 1 | No eligible port |
| sel_port_o | output | PIDX_W | Chosen port index |

## Verification
A snapshot refresh and a packet acceptance can land on the same edge. The decision must then use the old snapshot while the new one is loaded. The bench forces this by lining up a packet with the refresh edge of its own period model, and by running a stretch with a period of zero, where every edge refreshes while the live occupancies change each cycle. A table write to the group a packet is reading in that same cycle is the second overlap: the packet must see the old entry, and the next packet must see the new one. Every result is compared with a scoring function in the bench that works from a model snapshot and a model table.

// File: rtl/eps_pkg.sv
package eps_pkg;

  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eps_snapshot.sv
module eps_snapshot #(
  parameter int NPORT = 8,
  parameter int OCC_W = 8,
  parameter int PER_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PER_W-1:0]       period_i,
  input  logic [NPORT*OCC_W-1:0] occ_live_i,
  output logic [NPORT*OCC_W-1:0] snap_o
);

  logic [PER_W-1:0]       cnt_q;
  logic [NPORT*OCC_W-1:0] snap_q;
  logic                   take;

  assign take = (cnt_q >= period_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (take) begin
      cnt_q  <= '0;
      snap_q <= occ_live_i;   // whole vector in one edge
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign snap_o = snap_q;

  // R7: snapshot only moves on a refresh edge
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(snap_q));

  // R7: a refresh restarts the interval
  a_r7_cnt_restart: assert property (@(posedge clk) disable iff (rst)
    take |=> (cnt_q == '0));

endmodule

// File: rtl/eps_group_table.sv
module eps_group_table #(
  parameter int NGROUP = 16,
  parameter int NPORT  = 8,
  parameter int GID_W  = 4
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [GID_W-1:0] waddr_i,
  input  logic [NPORT-1:0] wmask_i,
  input  logic [GID_W-1:0] raddr_i,
  output logic [NPORT-1:0] rmask_o
);

  logic [NPORT-1:0] mem [NGROUP];
  logic [NPORT-1:0] rd_q;

  // read-first single clock RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wmask_i;
    rd_q <= mem[raddr_i];
  end

  assign rmask_o = rd_q;

endmodule

// File: rtl/eps_score.sv
module eps_score #(
  parameter int NPORT  = 8,
  parameter int OCC_W  = 8,
  parameter int WT_W   = 8,
  parameter int NORM_W = 4,
  parameter int SC_W   = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   weighted_i,
  input  logic [NORM_W-1:0]      norm_i,
  input  logic [NPORT*OCC_W-1:0] occ_i,
  input  logic [NPORT*WT_W-1:0]  wt_i,
  output logic [NPORT*SC_W-1:0]  score_o
);

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic signed [SC_W-1:0] occ_s, nrm_s, wt_s, raw, sc_q;

    always_comb begin
      occ_s = SC_W'(occ_i[g*OCC_W +: OCC_W]);
      nrm_s = SC_W'(norm_i);
      wt_s  = SC_W'(wt_i[g*WT_W +: WT_W]);
      raw   = weighted_i ? (nrm_s * occ_s - wt_s) : occ_s;
    end

    always_ff @(posedge clk) begin
      if (rst) sc_q <= '0;
      else     sc_q <= raw;
    end

    assign score_o[g*SC_W +: SC_W] = sc_q;
  end

endmodule

// File: rtl/eps_pick.sv
module eps_pick #(
  parameter int NPORT  = 8,
  parameter int SC_W   = 13,
  parameter int PIDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [NPORT-1:0]      elig_i,
  input  logic [NPORT*SC_W-1:0] score_i,
  output logic                  out_valid_o,
  output logic                  out_drop_o,
  output logic [PIDX_W-1:0]     out_port_o
);

  logic                   found;
  logic signed [SC_W-1:0] best;
  logic [PIDX_W-1:0]      bidx;

  // strict less-than keeps the lowest index on a tie
  always_comb begin
    found = 1'b0;
    best  = '0;
    bidx  = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (elig_i[i] && (!found || $signed(score_i[i*SC_W +: SC_W]) < best)) begin
        found = 1'b1;
        best  = $signed(score_i[i*SC_W +: SC_W]);
        bidx  = PIDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_drop_o  <= 1'b0;
      out_port_o  <= '0;
    end else begin
      out_valid_o <= valid_i;
      out_drop_o  <= valid_i && !found;
      out_port_o  <= (valid_i && found) ? bidx : '0;
    end
  end

  // R1 and R5: a routed result names a port that was eligible
  a_r1_port_eligible: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_drop_o) |->
      (($past(elig_i) & (NPORT'(1) << out_port_o)) != '0));

  // R6: drop exactly when nothing was eligible
  a_r6_drop_when_empty: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> (out_drop_o == ($past(elig_i) == '0)));

  // R6: a drop carries port zero inside a valid result
  a_r6_drop_port_zero: assert property (@(posedge clk) disable iff (rst)
    out_drop_o |-> (out_valid_o && out_port_o == '0));

endmodule

// File: rtl/egress_port_selector.sv
module egress_port_selector import eps_pkg::*; #(
  parameter int NPORT  = 8,
  parameter int NGROUP = 16,
  parameter int OCC_W  = 8,
  parameter int WT_W   = 8,
  parameter int NORM_W = 4,
  parameter int PER_W  = 8,
  localparam int GID_W  = idx_w(NGROUP),
  localparam int PIDX_W = idx_w(NPORT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pkt_valid_i,
  input  logic [GID_W-1:0]       pkt_group_i,
  input  logic                   tbl_we_i,
  input  logic [GID_W-1:0]       tbl_addr_i,
  input  logic [NPORT-1:0]       tbl_mask_i,
  input  logic [NPORT*OCC_W-1:0] occ_live_i,
  input  logic [NPORT*WT_W-1:0]  weight_i,
  input  logic [NPORT-1:0]       port_down_i,
  input  logic                   asym_mode_i,
  input  logic [NORM_W-1:0]      norm_i,
  input  logic [PER_W-1:0]       sample_period_i,
  output logic                   sel_valid_o,
  output logic                   sel_drop_o,
  output logic [PIDX_W-1:0]      sel_port_o
);

  localparam int SC_W = max2(OCC_W + NORM_W, WT_W) + 1;

  logic [NPORT*OCC_W-1:0] snap;
  logic [NPORT-1:0]       member;
  logic [NPORT*SC_W-1:0]  score;
  logic                   v1_q;
  logic [NPORT-1:0]       up1_q;
  logic [NPORT-1:0]       elig;

  eps_snapshot #(.NPORT(NPORT), .OCC_W(OCC_W), .PER_W(PER_W)) u_snap (
    .clk(clk), .rst(rst), .period_i(sample_period_i),
    .occ_live_i(occ_live_i), .snap_o(snap)
  );

  eps_group_table #(.NGROUP(NGROUP), .NPORT(NPORT), .GID_W(GID_W)) u_tbl (
    .clk(clk), .we_i(tbl_we_i), .waddr_i(tbl_addr_i), .wmask_i(tbl_mask_i),
    .raddr_i(pkt_group_i), .rmask_o(member)
  );

  eps_score #(.NPORT(NPORT), .OCC_W(OCC_W), .WT_W(WT_W), .NORM_W(NORM_W),
              .SC_W(SC_W)) u_score (
    .clk(clk), .rst(rst), .weighted_i(asym_mode_i), .norm_i(norm_i),
    .occ_i(snap), .wt_i(weight_i), .score_o(score)
  );

  // stage one side registers travelling with the scores
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q  <= 1'b0;
      up1_q <= '0;
    end else begin
      v1_q  <= pkt_valid_i;
      up1_q <= ~port_down_i;
    end
  end

  assign elig = member & up1_q;

  eps_pick #(.NPORT(NPORT), .SC_W(SC_W), .PIDX_W(PIDX_W)) u_pick (
    .clk(clk), .rst(rst), .valid_i(v1_q), .elig_i(elig), .score_i(score),
    .out_valid_o(sel_valid_o), .out_drop_o(sel_drop_o), .out_port_o(sel_port_o)
  );

  // R8: every accepted packet is answered two cycles later
  a_r8_answer: assert property (@(posedge clk) disable iff (rst)
    pkt_valid_i |-> ##2 sel_valid_o);

  // R8: no result appears without a packet
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid_i |-> ##2 !sel_valid_o);

endmodule

// File: tb/tb_egress_port_selector.sv
module tb_egress_port_selector;
  localparam int NPORT = 8, NGROUP = 16, OCC_W = 8, WT_W = 8, NORM_W = 4, PER_W = 8;
  localparam int GID_W = 4, PIDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_valid = 1'b0;
  logic [GID_W-1:0] pkt_group = '0;
  logic tbl_we = 1'b0;
  logic [GID_W-1:0] tbl_addr = '0;
  logic [NPORT-1:0] tbl_mask = '0;
  logic [NPORT*OCC_W-1:0] occ_live = '0;
  logic [NPORT*WT_W-1:0] weight = '0;
  logic [NPORT-1:0] port_down = '0;
  logic asym = 1'b0;
  logic [NORM_W-1:0] norm = 4'd1;
  logic [PER_W-1:0] period = 8'd15;
  logic sel_valid, sel_drop;
  logic [PIDX_W-1:0] sel_port;

  int checks = 0, failures = 0;
  string tag = "R2";
  bit done = 1'b0;

  always #2 clk = ~clk;

  egress_port_selector #(.NPORT(NPORT), .NGROUP(NGROUP), .OCC_W(OCC_W), .WT_W(WT_W),
    .NORM_W(NORM_W), .PER_W(PER_W)) dut (
    .clk(clk), .rst(rst), .pkt_valid_i(pkt_valid), .pkt_group_i(pkt_group),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_mask_i(tbl_mask),
    .occ_live_i(occ_live), .weight_i(weight), .port_down_i(port_down),
    .asym_mode_i(asym), .norm_i(norm), .sample_period_i(period),
    .sel_valid_o(sel_valid), .sel_drop_o(sel_drop), .sel_port_o(sel_port));

  // ---- reference model built from the requirements ----
  int unsigned mcnt = 0;
  logic [NPORT*OCC_W-1:0] msnap = '0;
  logic [NPORT-1:0] mtbl [NGROUP];
  bit m1_v = 0, m2_v = 0, m1_d = 0, m2_d = 0;
  int m1_p = 0, m2_p = 0;
  string m1_t = "", m2_t = "";

  function automatic void ref_pick(input logic [NPORT-1:0] cand,
      input logic [NPORT*OCC_W-1:0] snp, input logic [NPORT*WT_W-1:0] wts,
      input logic [NORM_W-1:0] nrm, input bit wmode, output bit drop, output int port);
    int best = 0;
    bit found = 0;
    port = 0;
    for (int i = 0; i < NPORT; i++) begin
      if (cand[i]) begin
        int o = int'(snp[i*OCC_W +: OCC_W]);
        int w = int'(wts[i*WT_W +: WT_W]);
        int s = wmode ? int'(nrm) * o - w : o;
        if (!found || s < best) begin
          found = 1; best = s; port = i;
        end
      end
    end
    drop = !found;
  endfunction

  always @(posedge clk) begin
    bit d;
    int p;
    if (rst) begin
      mcnt <= 0; msnap <= '0;
      m1_v <= 0; m2_v <= 0;
    end else begin
      ref_pick(mtbl[pkt_group] & ~port_down, msnap, weight, norm, asym, d, p);
      m1_v <= pkt_valid; m1_d <= d; m1_p <= p; m1_t <= tag;
      m2_v <= m1_v; m2_d <= m1_d; m2_p <= m1_p; m2_t <= m1_t;
      if (mcnt >= int'(period)) begin mcnt <= 0; msnap <= occ_live; end
      else mcnt <= mcnt + 1;
    end
    if (tbl_we) mtbl[tbl_addr] <= tbl_mask;
  end

  task automatic report(string req, int act, int exp);
    failures++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (sel_valid !== m2_v) report("R8 valid", int'(sel_valid), int'(m2_v));
      else if (m2_v) begin
        checks++;
        if (sel_drop !== m2_d) report("R6 drop", int'(sel_drop), int'(m2_d));
        else if (!m2_d && int'(sel_port) != m2_p) report(m2_t, int'(sel_port), m2_p);
      end
    end
  end

  // ---- stimulus helpers (called at a negedge) ----
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int g, string t);
    pkt_valid = 1'b1; pkt_group = GID_W'(g); tag = t;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic wr(int g, logic [NPORT-1:0] m);
    tbl_we = 1'b1; tbl_addr = GID_W'(g); tbl_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic set_occ(int i, int v);
    occ_live[i*OCC_W +: OCC_W] = OCC_W'(v);
  endtask

  task automatic set_wt(int i, int v);
    weight[i*WT_W +: WT_W] = WT_W'(v);
  endtask

  task automatic settle();
    step(int'(period) + 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPORT; i++) set_occ(i, 200 - 10 * i);
    step(5);
    rst = 1'b0;
    @(negedge clk);
    // R10: outputs cleared by reset
    checks++;
    if (sel_valid !== 1'b0 || sel_drop !== 1'b0 || sel_port !== '0)
      report("R10 reset outputs", int'({sel_valid, sel_drop, sel_port}), 0);

    // R10: before the first refresh all occupancies read zero -> lowest member
    wr(0, 8'hFF);
    send(0, "R10");
    step(3);
    for (int g = 1; g < NGROUP; g++) begin
      logic [NPORT-1:0] m;
      m = (g == 1) ? 8'b0000_0110 : (g == 2) ? 8'h00 : (g == 3) ? 8'h81 :
          NPORT'($urandom_range(1, 255));
      wr(g, m);
    end

    // R2: shortest queue
    for (int i = 0; i < NPORT; i++) set_occ(i, 100 + 7 * ((i * 5) % 8));
    settle();
    send(0, "R2"); send(1, "R2"); send(3, "R2");
    for (int i = 0; i < NPORT; i++) set_occ(i, 10 * (NPORT - i));
    settle();
    send(0, "R2"); send(1, "R2"); send(3, "R2"); step(2);

    // R4: ties go to lowest index
    for (int i = 0; i < NPORT; i++) set_occ(i, 50);
    settle();
    send(0, "R4"); send(1, "R4"); send(3, "R4");
    asym = 1'b1; norm = 4'd2; weight = '0;
    send(0, "R4"); asym = 1'b0; step(2);

    // R3: weighted scores, including negative ones
    for (int i = 0; i < NPORT; i++) begin set_occ(i, 20 + 3 * i); set_wt(i, 10 * i); end
    settle();
    asym = 1'b1;
    norm = 4'd1; send(0, "R3");
    norm = 4'd3; send(0, "R3");
    norm = 4'd0; send(0, "R3");
    set_wt(7, 255); norm = 4'd1; send(3, "R3");
    asym = 1'b0; step(2);

    // R5: down ports skipped
    settle();
    port_down = 8'b0000_0001; send(0, "R5");
    port_down = 8'b0111_1111; send(0, "R5");
    port_down = 8'b0000_0010; send(1, "R5");
    // R6: nothing left
    port_down = 8'b0000_0110; send(1, "R6");
    port_down = 8'h00; send(2, "R6");
    port_down = 8'hFF; send(0, "R6");
    port_down = 8'h00; step(2);

    // R1: write and lookup of the same group in one cycle
    tbl_we = 1'b1; tbl_addr = 4'd5; tbl_mask = 8'b1000_0000;
    send(5, "R1");
    tbl_we = 1'b0;
    send(5, "R1");
    wr(5, 8'b0001_0000); send(5, "R1"); step(2);

    // R7: refresh on the acceptance edge uses the old snapshot
    for (int i = 0; i < NPORT; i++) set_occ(i, 10 + 20 * i);
    settle();
    while (mcnt != int'(period)) @(negedge clk);
    for (int i = 0; i < NPORT; i++) set_occ(i, 240 - 20 * i);
    send(0, "R7"); send(0, "R7");
    step(3); send(0, "R7");
    settle(); send(0, "R7"); step(2);

    // R8/R9: back-to-back packets with live control changes
    for (int k = 0; k < 40; k++) begin
      pkt_valid = 1'b1; pkt_group = GID_W'($urandom_range(0, NGROUP - 1));
      asym = k[0]; norm = NORM_W'($urandom_range(0, 15));
      for (int i = 0; i < NPORT; i++) set_wt(i, $urandom_range(0, 255));
      port_down = NPORT'($urandom_range(0, 255)) & NPORT'($urandom_range(0, 255));
      tag = asym ? "R9" : "R8";
      @(negedge clk);
    end
    pkt_valid = 1'b0; step(3);

    // random traffic, two refresh periods
    for (int ph = 0; ph < 2; ph++) begin
      period = (ph == 0) ? 8'd15 : 8'd0;
      for (int k = 0; k < 3000; k++) begin
        pkt_valid = ($urandom_range(0, 9) < 7);
        pkt_group = GID_W'($urandom_range(0, NGROUP - 1));
        for (int i = 0; i < NPORT; i++) set_occ(i, $urandom_range(0, 255));
        if ($urandom_range(0, 7) == 0)
          for (int i = 0; i < NPORT; i++) set_wt(i, $urandom_range(0, 255));
        asym = ($urandom_range(0, 1) == 1);
        norm = NORM_W'($urandom_range(0, 15));
        port_down = ($urandom_range(0, 3) == 0) ? NPORT'($urandom_range(0, 255)) : '0;
        tbl_we = ($urandom_range(0, 15) == 0);
        tbl_addr = GID_W'($urandom_range(0, NGROUP - 1));
        tbl_mask = NPORT'($urandom_range(0, 255));
        tag = (ph == 1) ? "R7" : (asym ? "R3" : "R2");
        @(negedge clk);
      end
      pkt_valid = 1'b0; tbl_we = 1'b0; step(4);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule